// File: doc/BRIEF.md
# Power-Down Wake-Up Sequencer

This block owns the sleep state of a small microcontroller and the return to normal running. Software asks for sleep with a one-cycle request. The block then drops the oscillator enable and gates the CPU and peripheral clocks. Two events can end the sleep. The first is a low level on one of the active-low wake pins, counted only when that pin is enabled, set to level-sensitive and set to top priority. The second is the external reset pin.

Either event raises the oscillator enable at once, without any clock. The block then counts a programmable number of cycles so the oscillator can settle, and only after that does it bring the clocks back. An interrupt wake holds execution until the wake pin is released. It then issues a resume strobe, and the recorded wake source lets the vectoring logic run the handler first. A reset wake resumes execution for a short window with internal RAM blocked, then requests re-initialisation of the special-function registers. Internal RAM is never cleared.

The block's own flops are clocked by an always-on clock `clk`, and the settling count is in cycles of that clock. The wake pins and the reset pin reach the sequencer through a two-flop synchroniser. So a pin change made between clock edge c and edge c+1 reaches the state register at edge c+3.

Top module: `pdwake_seq`

## Requirements
- R1: After the synchronous `rst`, the block is running: `osc_en`, `cpu_clk_en` and `per_clk_en` are 1, and `pd_bit`, `ram_block`, `resume_pulse`, `sfr_reinit` and `wake_src` are 0.
- R2: A `pd_set` pulse while running puts the block to sleep at the next clock edge. `cpu_clk_en`, `per_clk_en` and `osc_en` then read 0 (no wake level present) and `pd_bit` reads 1.
- R3: A low level on wake pin i wakes the block only when `wake_en[i]`, `wake_level[i]` and `wake_top[i]` are all 1. If any of them is 0, `osc_en` and the clock enables stay 0 for as long as the pin is held low.
- R4: During sleep, a qualified low wake level or a high `ext_rst` raises `osc_en` combinationally, with no clock edge. A high `ext_rst` also forces `pd_bit` to 0 combinationally.
- R5: The clock enables rise exactly `stab_cycles` clock cycles after the sequencer enters the restart state, that is at edge c+3+`stab_cycles` for a pin change made after edge c. A `stab_cycles` value of 0 acts as 1.
- R6: If the wake pin is released before the settling count ends, the block returns to sleep. The clocks stay off, `osc_en` drops to 0 and `pd_bit` stays 1.
- R7: On an interrupt wake, the clocks come back while the pin is still held low. `pd_bit` clears at that point and `ram_block` stays 0. `resume_pulse` is high for exactly one cycle, three edges after the pin is released. No `sfr_reinit` is issued.
- R8: `wake_src` bit i (bit 0 = pin 0, bit 1 = pin 1) is set for the pin that caused an interrupt wake. It holds until the next sleep entry clears it.
- R9: On a reset wake, the clocks return and `resume_pulse` fires in the same cycle. `ram_block` is then high for exactly `RST_WIN` cycles, and `sfr_reinit` pulses for one cycle as `ram_block` falls, with the clocks left running.
- R10: A rising edge on `ext_rst` while running raises `ram_block` three edges later for `RST_WIN` cycles, then `sfr_reinit` pulses once. No `resume_pulse` is issued.
- R11: `pd_set` is ignored outside the running state. A pulse while waiting for pin release leaves the clocks running after the resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst | input | 1 | Synchronous active-high block reset |
| pd_set | input | 1 | Software request to enter sleep |
| wake_n | input | N_WAKE | Active-low external wake pins |
| wake_en | input | N_WAKE | Per-pin interrupt enable |
| wake_level | input | N_WAKE | Per-pin level-sensitive configuration |
| wake_top | input | N_WAKE | Per-pin highest-priority configuration |
| ext_rst | input | 1 | External reset pin, active high |
| stab_cycles | input | CNT_W | Oscillator settling count in cycles |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| resume_pulse | output | 1 | One-cycle execution resume strobe |
| sfr_reinit | output | 1 | One-cycle register re-initialise request |
| ram_block | output | 1 | Blocks internal RAM access |
| pd_bit | output | 1 | Readable sleep control bit |
| wake_src | output | N_WAKE | Pins that caused the last interrupt wake |

## Verification
The bench builds the block with `N_WAKE=2`, the default `CNT_W=11` and `RST_WIN=3`. The short reset window lets every cycle of `ram_block` be checked, both window edges included. The `stab_cycles` port is driven with 0, 5, 8 and 9. These values test the zero-as-one case and confirm that the clock return shifts one-for-one with the count. They also make a wake pin released mid-count fall back to sleep within a few cycles. The scoreboard predicts the exact cycle of every clock-enable edge, resume strobe and re-initialise pulse. Any event it did not predict is reported as a failure, and this is how the ignored-stimulus cases are caught.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

    typedef enum logic [2:0] {
        PS_RUN    = 3'd0,
        PS_SLEEP  = 3'd1,
        PS_WARM   = 3'd2,
        PS_HOLD   = 3'd3,
        PS_RSTWIN = 3'd4
    } pw_state_e;

    typedef struct packed {
        logic osc;
        logic cpu;
        logic per;
        logic ramblk;
    } gate_t;

    // Per-state gating of oscillator, clocks and RAM access.
    function automatic gate_t gates_for(pw_state_e s);
        gate_t g;
        case (s)
            PS_RUN:    g = '{osc: 1'b1, cpu: 1'b1, per: 1'b1, ramblk: 1'b0};
            PS_SLEEP:  g = '{osc: 1'b0, cpu: 1'b0, per: 1'b0, ramblk: 1'b0};
            PS_WARM:   g = '{osc: 1'b1, cpu: 1'b0, per: 1'b0, ramblk: 1'b0};
            PS_HOLD:   g = '{osc: 1'b1, cpu: 1'b1, per: 1'b1, ramblk: 1'b0};
            PS_RSTWIN: g = '{osc: 1'b1, cpu: 1'b1, per: 1'b1, ramblk: 1'b1};
            default:   g = '{osc: 1'b1, cpu: 1'b1, per: 1'b1, ramblk: 1'b0};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/pdw_sync.sv
module pdw_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pdw_wake_qual.sv
module pdw_wake_qual #(
    parameter int N = 2
) (
    input  logic [N-1:0] pin_n,
    input  logic [N-1:0] en,
    input  logic [N-1:0] level_cfg,
    input  logic [N-1:0] top_cfg,
    output logic [N-1:0] qual
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        assign qual[i] = ~pin_n[i] & en[i] & level_cfg[i] & top_cfg[i];
    end
endmodule

// File: rtl/pdw_timer.sv
module pdw_timer #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;
    logic [W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
    assign done    = cnt_inc >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (run && !done)
            cnt <= cnt + 1'b1;
    end

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (run && limit != '0) |-> (cnt < limit));
endmodule

// File: rtl/pdwake_seq.sv
module pdwake_seq
    import pdw_pkg::*;
#(
    parameter int N_WAKE  = 2,
    parameter int CNT_W   = 11,
    parameter int RST_WIN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_set,
    input  logic [N_WAKE-1:0] wake_n,
    input  logic [N_WAKE-1:0] wake_en,
    input  logic [N_WAKE-1:0] wake_level,
    input  logic [N_WAKE-1:0] wake_top,
    input  logic              ext_rst,
    input  logic [CNT_W-1:0]  stab_cycles,
    output logic              osc_en,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              resume_pulse,
    output logic              sfr_reinit,
    output logic              ram_block,
    output logic              pd_bit,
    output logic [N_WAKE-1:0] wake_src
);
    localparam int WIN_W = $clog2(RST_WIN + 1);
    localparam logic [WIN_W-1:0] WIN_LIM = WIN_W'(RST_WIN);

    pw_state_e         st, nxt;
    gate_t             g;
    logic [N_WAKE-1:0] qual_raw, wake_s, src_q;
    logic              rst_s, rst_d, rst_rise;
    logic              via_rst, pd_q;
    logic              stab_done, win_done;
    logic              held;

    pdw_wake_qual #(.N(N_WAKE)) u_qual (
        .pin_n     (wake_n),
        .en        (wake_en),
        .level_cfg (wake_level),
        .top_cfg   (wake_top),
        .qual      (qual_raw)
    );

    pdw_sync #(.W(N_WAKE + 1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ext_rst, qual_raw}),
        .q   ({rst_s, wake_s})
    );

    pdw_timer #(.W(CNT_W)) u_stab (
        .clk   (clk),
        .rst   (rst),
        .clear (st != PS_WARM),
        .run   (st == PS_WARM),
        .limit (stab_cycles),
        .done  (stab_done)
    );

    pdw_timer #(.W(WIN_W)) u_win (
        .clk   (clk),
        .rst   (rst),
        .clear (st != PS_RSTWIN),
        .run   (st == PS_RSTWIN),
        .limit (WIN_LIM),
        .done  (win_done)
    );

    assign rst_rise = rst_s & ~rst_d;
    assign held     = |(wake_s & src_q);

    always_comb begin
        nxt = st;
        case (st)
            PS_RUN:
                if (rst_rise)    nxt = PS_RSTWIN;
                else if (pd_set) nxt = PS_SLEEP;
            PS_SLEEP:
                if (rst_s || (|wake_s)) nxt = PS_WARM;
            PS_WARM:
                if (stab_done) begin
                    if (via_rst || rst_s) nxt = PS_RSTWIN;
                    else if (held)        nxt = PS_HOLD;
                    else                  nxt = PS_SLEEP;
                end
            PS_HOLD:
                if (rst_rise)   nxt = PS_RSTWIN;
                else if (!held) nxt = PS_RUN;
            PS_RSTWIN:
                if (win_done) nxt = PS_RUN;
            default: nxt = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= PS_RUN;
            rst_d        <= 1'b0;
            via_rst      <= 1'b0;
            pd_q         <= 1'b0;
            src_q        <= '0;
            resume_pulse <= 1'b0;
            sfr_reinit   <= 1'b0;
        end else begin
            st           <= nxt;
            rst_d        <= rst_s;
            resume_pulse <= ((st == PS_WARM) && (nxt == PS_RSTWIN)) ||
                            ((st == PS_HOLD) && (nxt == PS_RUN));
            sfr_reinit   <= (st == PS_RSTWIN) && (nxt == PS_RUN);

            if (st == PS_RUN && nxt == PS_SLEEP) begin
                pd_q  <= 1'b1;
                src_q <= '0;
            end
            if (st == PS_SLEEP && rst_s) begin
                pd_q    <= 1'b0;
                via_rst <= 1'b1;
                src_q   <= '0;
            end else if (st == PS_SLEEP && nxt == PS_WARM) begin
                src_q <= wake_s;
            end
            if (st == PS_WARM) begin
                if (rst_s) via_rst <= 1'b1;
                if (nxt == PS_HOLD || nxt == PS_RSTWIN) pd_q <= 1'b0;
                if (nxt == PS_SLEEP || nxt == PS_RSTWIN) src_q <= '0;
                if (nxt != PS_WARM) via_rst <= 1'b0;
            end
        end
    end

    assign g          = gates_for(st);
    assign osc_en     = g.osc | ext_rst | (|qual_raw);
    assign cpu_clk_en = g.cpu;
    assign per_clk_en = g.per;
    assign ram_block  = g.ramblk;
    assign pd_bit     = pd_q & ~ext_rst;
    assign wake_src   = src_q;

    assert_clk_needs_osc_R2: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> osc_en);
    assert_resume_single_R7: assert property (@(posedge clk) disable iff (rst)
        resume_pulse |=> !resume_pulse);
    assert_reinit_after_window_R9: assert property (@(posedge clk) disable iff (rst)
        sfr_reinit |-> $past(ram_block));
    assert_window_pd_clear_R9: assert property (@(posedge clk) disable iff (rst)
        ram_block |-> !pd_bit);
    assert_src_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (st == PS_HOLD && $past(st) == PS_HOLD) |-> $stable(wake_src));
    assert_hold_has_src_R7: assert property (@(posedge clk) disable iff (rst)
        (st == PS_HOLD) |-> (|wake_src));
endmodule

// File: tb/pdwake_seq_bench.sv
module pdwake_seq_bench;
    localparam int NW  = 2;
    localparam int CW  = 11;
    localparam int WIN = 3;
    localparam int EV_OFF = 0, EV_ON = 1, EV_RES = 2, EV_RI = 3;

    logic          clk = 1'b0;
    logic          rst, pd_set, ext_rst;
    logic [NW-1:0] wake_n, wake_en, wake_level, wake_top, wake_src;
    logic [CW-1:0] stab_cycles;
    logic          osc_en, cpu_clk_en, per_clk_en, resume_pulse, sfr_reinit, ram_block, pd_bit;

    always #4 clk = ~clk;

    pdwake_seq #(.N_WAKE(NW), .CNT_W(CW), .RST_WIN(WIN)) u_pdwake_seq (
        .clk(clk), .rst(rst), .pd_set(pd_set), .wake_n(wake_n), .wake_en(wake_en),
        .wake_level(wake_level), .wake_top(wake_top), .ext_rst(ext_rst),
        .stab_cycles(stab_cycles), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .resume_pulse(resume_pulse), .sfr_reinit(sfr_reinit),
        .ram_block(ram_block), .pd_bit(pd_bit), .wake_src(wake_src)
    );

    typedef struct { int kind; int at; string req; } ev_t;
    ev_t  expq[$];
    int   cyc = 0;
    int   n_chk = 0, n_fail = 0;
    bit   finished = 0;
    logic prev_clk = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic string kname(int k);
        case (k)
            EV_OFF:  return "clk_off";
            EV_ON:   return "clk_on";
            EV_RES:  return "resume";
            default: return "reinit";
        endcase
    endfunction

    task automatic expect_ev(int k, int at, string req);
        ev_t e;
        e.kind = k; e.at = at; e.req = req;
        expq.push_back(e);
    endtask

    task automatic seen(int k);
        ev_t e;
        n_chk++;
        if (expq.size() == 0) begin
            n_fail++;
            $display("FAIL R3/R6/R10/R11 unexpected event: actual %s at cycle %0d, expected none",
                     kname(k), cyc);
        end else begin
            e = expq.pop_front();
            if (e.kind != k || e.at != cyc) begin
                n_fail++;
                $display("FAIL %s event: actual %s at cycle %0d, expected %s at cycle %0d",
                         e.req, kname(k), cyc, kname(e.kind), e.at);
            end
        end
    endtask

    // Monitor: turns output edges and strobes into events, compared against the queue.
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            if (prev_clk && !cpu_clk_en) seen(EV_OFF);
            if (!prev_clk && cpu_clk_en) seen(EV_ON);
            if (resume_pulse)            seen(EV_RES);
            if (sfr_reinit)              seen(EV_RI);
        end
        prev_clk = cpu_clk_en;
    end

    task automatic chk(string req, string what, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic enter_pd(string req);
        int c;
        c = cyc;
        pd_set = 1'b1;
        expect_ev(EV_OFF, c + 1, req);
        @(negedge clk);
        pd_set = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int c, r;
        rst = 1'b1; pd_set = 1'b0; ext_rst = 1'b0;
        wake_n = '1; wake_en = '0; wake_level = '0; wake_top = '0;
        stab_cycles = CW'(8);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", "osc_en", osc_en, 1); chk("R1", "cpu_clk_en", cpu_clk_en, 1);
        chk("R1", "per_clk_en", per_clk_en, 1); chk("R1", "pd_bit", pd_bit, 0);
        chk("R1", "ram_block", ram_block, 0); chk("R1", "wake_src", wake_src, 0);
        chk("R1", "resume/reinit", {resume_pulse, sfr_reinit}, 0);

        // R2 sleep entry
        enter_pd("R2");
        chk("R2", "pd_bit", pd_bit, 1); chk("R2", "osc_en", osc_en, 0);
        chk("R2", "per_clk_en", per_clk_en, 0);

        // R3 unqualified wake on pin 0: disabled, edge-configured, low priority
        for (int k = 0; k < 3; k++) begin
            wake_en[0] = (k != 0); wake_level[0] = (k != 1); wake_top[0] = (k != 2);
            wake_n[0] = 1'b0;
            #1 chk("R3", "osc_en", osc_en, 0);
            repeat (10) @(negedge clk);
            chk("R3", "cpu_clk_en", cpu_clk_en, 0);
            wake_n[0] = 1'b1;
            @(negedge clk);
        end

        // R6 release before settling, R4 async oscillator enable
        wake_en = 2'b11; wake_level = 2'b11; wake_top = 2'b11;
        stab_cycles = CW'(8);
        c = cyc; wake_n[0] = 1'b0;
        #1 chk("R4", "osc_en async on wake", osc_en, 1);
        repeat (2) @(negedge clk);
        wake_n[0] = 1'b1;
        wait_until(c + 13);
        chk("R6", "cpu_clk_en", cpu_clk_en, 0); chk("R6", "osc_en", osc_en, 0);
        chk("R6", "pd_bit", pd_bit, 1);

        // R5/R7/R8/R11 interrupt wake on pin 1
        stab_cycles = CW'(5);
        c = cyc; wake_n[1] = 1'b0;
        expect_ev(EV_ON, c + 8, "R5");
        wait_until(c + 10);
        chk("R8", "wake_src", wake_src, 2'b10); chk("R7", "pd_bit", pd_bit, 0);
        chk("R7", "ram_block", ram_block, 0);
        pd_set = 1'b1; @(negedge clk); pd_set = 1'b0;   // R11 ignored while held
        @(negedge clk);
        r = cyc; wake_n[1] = 1'b1;
        expect_ev(EV_RES, r + 3, "R7");
        wait_until(r + 8);
        chk("R11", "cpu_clk_en after resume", cpu_clk_en, 1);
        chk("R8", "wake_src held", wake_src, 2'b10);

        enter_pd("R2");
        chk("R8", "wake_src cleared", wake_src, 0);

        // R9 reset wake with stab 0 (acts as 1, R5)
        stab_cycles = '0;
        c = cyc; ext_rst = 1'b1;
        #1 chk("R4", "pd_bit async clear", pd_bit, 0); chk("R4", "osc_en async on reset", osc_en, 1);
        expect_ev(EV_ON, c + 4, "R5");
        expect_ev(EV_RES, c + 4, "R9");
        expect_ev(EV_RI, c + 4 + WIN, "R9");
        repeat (2) @(negedge clk);
        ext_rst = 1'b0;
        wait_until(c + 4);           chk("R9", "ram_block first", ram_block, 1);
        wait_until(c + 4 + WIN - 1); chk("R9", "ram_block last", ram_block, 1);
        wait_until(c + 4 + WIN);     chk("R9", "ram_block end", ram_block, 0);
        chk("R9", "cpu_clk_en", cpu_clk_en, 1);

        // R10 reset edge while running
        repeat (2) @(negedge clk);
        c = cyc; ext_rst = 1'b1;
        expect_ev(EV_RI, c + 3 + WIN, "R10");
        @(negedge clk);
        ext_rst = 1'b0;
        wait_until(c + 2);       chk("R10", "ram_block before", ram_block, 0);
        wait_until(c + 3);       chk("R10", "ram_block", ram_block, 1);
        wait_until(c + 3 + WIN); chk("R10", "ram_block end", ram_block, 0);

        // R5 second settling value on pin 0
        repeat (2) @(negedge clk);
        enter_pd("R2");
        stab_cycles = CW'(9);
        c = cyc; wake_n[0] = 1'b0;
        expect_ev(EV_ON, c + 12, "R5");
        wait_until(c + 11); chk("R5", "cpu_clk_en one early", cpu_clk_en, 0);
        wait_until(c + 13);
        wake_n[0] = 1'b1;
        expect_ev(EV_RES, c + 16, "R7");
        wait_until(c + 20);
        chk("R8", "wake_src pin0", wake_src, 2'b01);

        repeat (3) @(negedge clk);
        while (expq.size() != 0) begin
            ev_t e;
            e = expq.pop_front();
            n_chk++; n_fail++;
            $display("FAIL %s missing event: actual none expected %s at cycle %0d",
                     e.req, kname(e.kind), e.at);
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule